// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter

This block is one digit of a synchronous counter. It holds a small count that steps by one on each rising clock edge while its active-low carry input is low. A parameter picks the last value of the count: 9 for a decimal digit or 15 for a full 4-bit binary nibble. After the last value the count returns to zero.

An asynchronous load input copies a parallel data word into the count at once, without waiting for the clock. An asynchronous clear input forces the count to zero and overrides the load. The active-low carry output goes low only while the stage is enabled and holding its last value.

Several stages share one clock to form a multi-digit counter. Each stage's carry output drives the carry input of the next stage, and the first stage's carry input is held low. Every digit of the chain changes on the same clock edge, so logic that decodes the outputs sees no ripple glitches.

Top module: `casc_counter`

## Requirements
- R1: On a rising clock edge with `ci_n` low, `load` low and `clr` low, a count below MAX_COUNT increases by exactly one, and all bits of `q` take their new values on that edge (for example 7 to 8, where every bit flips).
- R2: On a rising clock edge with `ci_n` high, the count keeps its value.
- R3: On an enabled rising edge with the count at MAX_COUNT (9 by default), the count becomes 0.
- R4: `co_n` is combinational. It is low exactly when `ci_n` is low and the count equals MAX_COUNT, and high in every other case.
- R5: A high level on `load` copies `d` into `q` immediately, without a clock edge.
- R6: While `load` stays high, rising clock edges do not change the count. The first enabled edge after `load` falls resumes counting from the loaded value.
- R7: A high level on `clr` forces `q` to 0 immediately and overrides `load`. This holds for the reset state as well.
- R8: Loading `d` = 0 clears the count, with the same result as `clr`.
- R9: A loaded value above MAX_COUNT (for example 12 in decimal mode) appears on `q` unchanged. `co_n` stays high while `q` holds that value, and the next enabled edge takes the count to 0.
- R10: Three stages that share a clock, with each `co_n` driving the next stage's `ci_n`, count as one decimal number from 000 to 999 and wrap to 000. Each stage advances on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, active on the rising edge |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| load | input | 1 | Asynchronous parallel load of `d`, active high |
| ci_n | input | 1 | Count enable / carry in, active low |
| d | input | W (4) | Parallel load value |
| q | output | W (4) | Current count |
| co_n | output | 1 | Carry out, active low, drives the next stage's `ci_n` |

## Verification
The stimulus table drives a three-digit chain through several patterns:
- Runs from zero show that each digit steps by one.
- Loads of 5, 95 and 990 followed by counting show the single, double and triple carry ripple into the upper digits, and show that all digits update on the same edge.
- Spans with the chain's carry input held high tell a held count apart from a stepping one.

Directed cases check the following:
- An asynchronous load, checked before any clock edge, shows that loading does not depend on the clock.
- Clear asserted together with load shows that clear has priority.
- Load held high across an edge shows that load blocks counting.
- A loaded value of 12 shows the return to zero from an out-of-range value without a false carry.

// File: rtl/cc_pkg.sv
package cc_pkg;

  // Next count for a digit whose last value is maxv: values at or above maxv return to zero.
  function automatic logic [3:0] step_value(input logic [3:0] cur, input logic [3:0] maxv);
    if (cur >= maxv) return 4'd0;
    return cur + 4'd1;
  endfunction

  // True when the digit holds its last value.
  function automatic logic at_top(input logic [3:0] cur, input logic [3:0] maxv);
    return cur == maxv;
  endfunction

endpackage

// File: rtl/cc_next.sv
module cc_next #(
  parameter int W = 4,
  parameter int MAX_COUNT = 9
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         top
);
  localparam int FULL = (1 << W) - 1;
  localparam logic [W-1:0] MAXV = W'(MAX_COUNT);

  generate
    if (MAX_COUNT == FULL) begin : g_binary
      // The natural overflow of the adder gives the wrap.
      assign nxt = cur + W'(1);
      assign top = &cur;
    end else begin : g_modulo
      always_comb begin
        nxt = W'(cc_pkg::step_value(4'(cur), 4'(MAXV)));
        top = cc_pkg::at_top(4'(cur), 4'(MAXV));
      end
    end
  endgenerate
endmodule

// File: rtl/cc_state.sv
module cc_state #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] d,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  // Priority: clear, then load, then counting.
  always_ff @(posedge clk or posedge clr or posedge load) begin
    if (clr)       q <= '0;
    else if (load) q <= d;
    else if (adv)  q <= nxt;
  end
endmodule

// File: rtl/cc_carry.sv
module cc_carry (
  input  logic ci_n,
  input  logic top,
  output logic adv,
  output logic co_n
);
  assign adv  = ~ci_n;
  assign co_n = ~(top & ~ci_n);
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int W = 4,
  parameter int MAX_COUNT = 9
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic         ci_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         co_n
);
  logic [W-1:0] nxt;
  logic         top;   // named event: count is at its last value
  logic         adv;   // named event: this edge may step the count

  cc_next #(.W(W), .MAX_COUNT(MAX_COUNT)) u_next (
    .cur(q), .nxt(nxt), .top(top)
  );

  cc_carry u_carry (
    .ci_n(ci_n), .top(top), .adv(adv), .co_n(co_n)
  );

  cc_state #(.W(W)) u_state (
    .clk(clk), .clr(clr), .load(load), .adv(adv),
    .d(d), .nxt(nxt), .q(q)
  );
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int W = 4,
  parameter int MAX_COUNT = 9
) (
  input logic         clk,
  input logic         clr,
  input logic         load,
  input logic         ci_n,
  input logic [W-1:0] q,
  input logic         co_n,
  input logic         top,
  input logic         adv
);
  localparam logic [W-1:0] MAXV = W'(MAX_COUNT);

  // Set by any asynchronous clear or load since the previous clock edge.
  logic hit;
  always_ff @(posedge clk or posedge clr or posedge load) begin
    if (clr || load) hit <= 1'b1;
    else             hit <= 1'b0;
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (clr)
    (!ci_n && !load && q < MAXV) |=> (hit || q == W'($past(q) + W'(1))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (clr)
    (ci_n && !load) |=> (hit || $stable(q)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (clr)
    (!ci_n && !load && q == MAXV) |=> (hit || q == '0));

  assert_carry_R4: assert property (@(posedge clk) disable iff (clr)
    !co_n |-> (q == MAXV && !ci_n && top && adv));

  assert_clear_R7: assert property (@(posedge clk)
    clr |-> (q == '0));
endmodule

bind casc_counter casc_counter_chk #(.W(W), .MAX_COUNT(MAX_COUNT)) u_chk (
  .clk(clk), .clr(clr), .load(load), .ci_n(ci_n),
  .q(q), .co_n(co_n), .top(top), .adv(adv)
);

// File: tb/casc_counter_test.sv
module casc_counter_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic clr = 1'b0;
  logic load = 1'b0;
  logic en_n = 1'b1;
  logic [3:0] dv [3];
  logic [3:0] qv [3];
  logic       cov [3];
  logic       cin [3];
  int checks = 0;
  int failures = 0;
  int ref_val = 0;

  always #2 clk = ~clk;

  assign cin[0] = en_n;
  assign cin[1] = cov[0];
  assign cin[2] = cov[1];

  for (genvar k = 0; k < 3; k++) begin : g_stage
    casc_counter uut (
      .clk(clk), .clr(clr), .load(load), .ci_n(cin[k]),
      .d(dv[k]), .q(qv[k]), .co_n(cov[k])
    );
  end

  // Stimulus table: value to load first (1000 means no load), carry-in level, clock cycles.
  localparam int NV = 7;
  localparam int LOADV [NV] = '{1000, 1000, 5, 95, 990, 1000, 498};
  localparam bit HOLDV [NV] = '{0, 1, 0, 0, 0, 1, 0};
  localparam int CYCV  [NV] = '{12, 4, 7, 9, 14, 3, 4};

  function automatic int total();
    return int'(qv[2]) * 100 + int'(qv[1]) * 10 + int'(qv[0]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_d(input int v);
    dv[0] = 4'(v % 10);
    dv[1] = 4'((v / 10) % 10);
    dv[2] = 4'((v / 100) % 10);
  endtask

  // Called just after tick: pulses load between clock edges.
  task automatic pulse_load(input int v);
    set_d(v);
    load = 1'b1;
    #1;
    check("R5 async load", total(), v);
    load = 1'b0;
    #0.5;
    ref_val = v;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_d(0);
    #1 clr = 1'b1;
    tick();
    tick();
    check("R7 reset state", total(), 0);
    check("R4 co_n high in reset", int'(cov[2]), 1);
    clr = 1'b0;

    // R10 chain run against a reference integer, plus R1 R2 R3 R4 every clock.
    for (int i = 0; i < NV; i++) begin
      if (LOADV[i] < 1000) pulse_load(LOADV[i]);
      en_n = HOLDV[i];
      #0.5;
      for (int c = 0; c < CYCV[i]; c++) begin
        tick();
        if (!HOLDV[i]) ref_val = (ref_val + 1) % 1000;
        check("R10 chain value", total(), ref_val);
        check("R4 top carry", int'(cov[2]), (!HOLDV[i] && ref_val == 999) ? 0 : 1);
        check("R4 digit0 carry", int'(cov[0]), (!HOLDV[i] && ref_val % 10 == 9) ? 0 : 1);
      end
    end

    // R3 and R10: full wrap 999 -> 000, with R2 hold at 999 first.
    tick();
    en_n = 1'b1;
    pulse_load(999);
    check("R4 co_n high when ci_n high", int'(cov[2]), 1);
    tick();
    check("R2 hold at 999", total(), 999);
    en_n = 1'b0;
    #0.5;
    check("R4 co_n low at 999 enabled", int'(cov[2]), 0);
    tick();
    check("R3 wrap to zero", total(), 0);

    // R1: 7 -> 8 flips all four bits on one edge.
    pulse_load(7);
    tick();
    check("R1 all bits on one edge", int'(qv[0]), 8);

    // R7: clear overrides load.
    set_d(321);
    clr = 1'b1;
    load = 1'b1;
    #1;
    check("R7 clear over load", total(), 0);
    load = 1'b0;
    clr = 1'b0;

    // R6: load held across an edge blocks counting.
    tick();
    set_d(543);
    load = 1'b1;
    tick();
    check("R6 load held blocks count", total(), 543);
    load = 1'b0;
    tick();
    check("R6 counts after load falls", total(), 544);

    // R8: loading zero clears.
    pulse_load(0);
    check("R8 zero load clears", total(), 0);

    // R9: out-of-range value 12 in the low digit.
    tick();
    en_n = 1'b1;
    set_d(0);
    dv[0] = 4'd12;
    load = 1'b1;
    #1;
    load = 1'b0;
    check("R9 out-of-range loaded", int'(qv[0]), 12);
    en_n = 1'b0;
    #0.5;
    check("R9 no carry at 12", int'(cov[0]), 1);
    tick();
    check("R9 returns to zero", int'(qv[0]), 0);
    check("R9 upper digit unchanged", int'(qv[1]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule